// File: doc/BRIEF.md
# Linked-List Block FIFO Allocator

This block keeps one shared dword buffer, cut into fixed blocks of four dwords, and lends those blocks to a set of logical channels. Software gives each channel a ring of blocks by writing a next-block pointer for every block, so the last block of a ring points back to the first. It then binds the channel to the ring by writing a starting block. From that point a producer pushes dwords into a selected channel and a consumer pops them in order. Each channel walks its own ring, and a four-dword block is the unit of every level the block reports.

Each channel has two thresholds, both counted in blocks. The receive threshold raises a request to drain the channel toward the host once enough complete blocks are filled. The transmit threshold raises a request to refill the channel once few enough blocks are still in use. The pointer and threshold stores are not cleared by reset. Software clears them by writing every entry.

Top module: `blkfifo_alloc`

## Requirements
- R1: While reset is held and in the first cycle after it, `push_ovf`, `pop_unf` and `pop_valid` are low. Every channel is unbound, so `rx_dma_req` and `tx_dma_req` are all zero.
- R2: Dwords popped from a channel come out in the order they were pushed. An accepted pop shows its dword on `pop_data` with `pop_valid` high in the cycle after `pop_req`.
- R3: A write with `cfg_sel`=0 sets the next-block pointer of block `cfg_idx` to `cfg_data`. After each fourth dword a channel moves on to the next block in its ring. A ring of N blocks holds exactly 4·N dwords, with data kept intact across the wrap from the last block back to the first.
- R4: A push to a channel that is full, or that is not bound, is dropped and leaves that channel unchanged. `push_ovf` is high in the following cycle.
- R5: A pop from an empty channel changes nothing. In the following cycle `pop_unf` is high, `pop_valid` is low, and `pop_data` holds its previous value.
- R6: A write with `cfg_sel`=2 sets the receive threshold of channel `cfg_idx`. `rx_dma_req[c]` is high exactly when channel c is bound, its threshold is nonzero, and floor(dwords/4) is at least that threshold.
- R7: A write with `cfg_sel`=3 sets the transmit threshold of channel `cfg_idx`. `tx_dma_req[c]` is high exactly when channel c is bound and ceil(dwords/4) is at most that threshold.
- R8: Channels share the block pool through disjoint rings. Traffic on one channel never changes the data, level or requests of another, even when every ring is full at the same time.
- R9: A write with `cfg_sel`=1 binds channel `cfg_idx` to block `cfg_data`. It empties that channel, and both its read and write positions start at offset 0 of that block. A push or pop to that channel in the same cycle is refused.
- R10: A push and a pop on the same channel in the same cycle both take effect. Fullness and emptiness are judged on the state before that cycle.
- R11: Next-block pointers and thresholds keep their values through reset. After a channel is bound again, it runs on the old ring and thresholds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Target: 0 next pointer, 1 bind start, 2 receive threshold, 3 transmit threshold |
| cfg_idx | input | IW | Block index (sel 0) or channel index (sel 1..3) |
| cfg_data | input | WMW | Pointer or threshold value |
| push_valid | input | 1 | Push one dword |
| push_ch | input | CW | Channel to push to |
| push_data | input | DW | Dword to push |
| pop_req | input | 1 | Pop one dword |
| pop_ch | input | CW | Channel to pop from |
| pop_valid | output | 1 | `pop_data` carries an accepted pop |
| pop_data | output | DW | Popped dword |
| push_ovf | output | 1 | Previous push was dropped |
| pop_unf | output | 1 | Previous pop found the channel empty |
| rx_dma_req | output | NUM_CH | Per-channel receive drain request |
| tx_dma_req | output | NUM_CH | Per-channel transmit refill request |

## Verification
The hardest state to reach from the ports is every ring full at once, with rings whose blocks are scattered through the pool. Only then would a wrong next-pointer walk or a shared-block mistake corrupt another channel's data. The stimulus builds rings of uneven length from a scrambled block order. It fills all channels round-robin until each one overflows, then drains them all and checks every dword and every request after every operation. Rebinding a partly filled channel and resetting while the rings stay in place are driven the same way.

// File: rtl/blkfifo_pkg.sv
// Shared definitions for the linked-list block FIFO allocator.
package blkfifo_pkg;
    // Configuration write targets selected by cfg_sel.
    typedef enum logic [1:0] {
        CFG_NEXT  = 2'd0,
        CFG_START = 2'd1,
        CFG_RXWM  = 2'd2,
        CFG_TXWM  = 2'd3
    } cfg_sel_e;

    // Dwords per block, fixed by the two-bit offset.
    localparam int DWORDS_PER_BLOCK = 4;
endpackage

// File: rtl/blkfifo_link_ram.sv
// Next-block pointer store. One write port, two combinational read ports.
// Assumes: contents are not reset; software writes every entry it uses.
module blkfifo_link_ram #(
    parameter int NUM_BLOCKS = 64,
    localparam int BPW = $clog2(NUM_BLOCKS)
) (
    input  logic           clk,
    input  logic           we,
    input  logic [BPW-1:0] waddr,
    input  logic [BPW-1:0] wdata,
    input  logic [BPW-1:0] raddr_a,
    output logic [BPW-1:0] rdata_a,
    input  logic [BPW-1:0] raddr_b,
    output logic [BPW-1:0] rdata_b
);
    logic [BPW-1:0] nxt_mem [NUM_BLOCKS];

    // Store a pointer when configuration targets it.
    always_ff @(posedge clk) begin
        if (we) nxt_mem[waddr] <= wdata;
    end

    assign rdata_a = nxt_mem[raddr_a];
    assign rdata_b = nxt_mem[raddr_b];
endmodule

// File: rtl/blkfifo_data_ram.sv
// Shared dword pool. One write port and one registered read port.
// Assumes: a read and a write never target the same word in one cycle.
module blkfifo_data_ram #(
    parameter int DEPTH = 256,
    parameter int DW    = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    // Write pushed dwords and register popped ones.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/blkfifo_chan_ctl.sv
// Per-channel position tracker: write and read block/offset plus dword count.
// Assumes: push_en/pop_en are only asserted when accepted by the top.
module blkfifo_chan_ctl #(
    parameter int BPW  = 6,
    localparam int CNTW = BPW + 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bind_en,
    input  logic [BPW-1:0]  bind_blk,
    input  logic            push_en,
    input  logic            pop_en,
    input  logic [BPW-1:0]  wr_next_blk,
    input  logic [BPW-1:0]  rd_next_blk,
    output logic [BPW-1:0]  wr_blk,
    output logic [1:0]      wr_off,
    output logic [BPW-1:0]  rd_blk,
    output logic [1:0]      rd_off,
    output logic [CNTW-1:0] count,
    output logic            bound
);
    // Advance positions along the ring and keep the dword count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bound  <= 1'b0;
            count  <= '0;
            wr_blk <= '0;
            rd_blk <= '0;
            wr_off <= 2'd0;
            rd_off <= 2'd0;
        end else if (bind_en) begin
            bound  <= 1'b1;
            count  <= '0;
            wr_blk <= bind_blk;
            rd_blk <= bind_blk;
            wr_off <= 2'd0;
            rd_off <= 2'd0;
        end else begin
            if (push_en) begin
                if (wr_off == 2'd3) wr_blk <= wr_next_blk;
                wr_off <= wr_off + 2'd1;
            end
            if (pop_en) begin
                if (rd_off == 2'd3) rd_blk <= rd_next_blk;
                rd_off <= rd_off + 2'd1;
            end
            if (push_en && !pop_en)      count <= count + 1'b1;
            else if (pop_en && !push_en) count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/blkfifo_wm_cmp.sv
// Per-channel thresholds and block-granular request compare.
// Assumes: threshold stores are not reset; software clears them.
module blkfifo_wm_cmp #(
    parameter int BPW  = 6,
    localparam int WMW  = BPW + 1,
    localparam int CNTW = BPW + 3
) (
    input  logic            clk,
    input  logic            rx_we,
    input  logic            tx_we,
    input  logic [WMW-1:0]  wm_data,
    input  logic [CNTW-1:0] count,
    input  logic            bound,
    output logic            rx_req,
    output logic            tx_req
);
    logic [WMW-1:0]  rx_wm;
    logic [WMW-1:0]  tx_wm;
    logic [CNTW-1:0] cnt_up;
    logic [WMW-1:0]  full_blks;
    logic [WMW-1:0]  used_blks;

    // Capture thresholds written by configuration.
    always_ff @(posedge clk) begin
        if (rx_we) rx_wm <= wm_data;
        if (tx_we) tx_wm <= wm_data;
    end

    // Complete blocks round down, occupied blocks round up.
    always_comb begin
        cnt_up    = count + CNTW'(3);
        full_blks = count[CNTW-1:2];
        used_blks = cnt_up[CNTW-1:2];
        rx_req    = bound && (rx_wm != '0) && (full_blks >= rx_wm);
        tx_req    = bound && (used_blks <= tx_wm);
    end
endmodule

// File: rtl/blkfifo_alloc.sv
// Linked-list block FIFO allocator top. Muxes the selected channel state,
// judges full/empty, drives the pool and link store, registers flags.
// Assumes: NUM_BLOCKS is a power of two, NUM_CH <= NUM_BLOCKS, channel
// selects are in range, and rings are not rewritten while a channel holds data.
module blkfifo_alloc
    import blkfifo_pkg::*;
#(
    parameter int NUM_BLOCKS = 64,
    parameter int NUM_CH     = 8,
    parameter int DW         = 32,
    localparam int BPW = $clog2(NUM_BLOCKS),
    localparam int CW  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int WMW = BPW + 1,
    localparam int IW  = (BPW > CW) ? BPW : CW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [IW-1:0]     cfg_idx,
    input  logic [WMW-1:0]    cfg_data,
    input  logic              push_valid,
    input  logic [CW-1:0]     push_ch,
    input  logic [DW-1:0]     push_data,
    input  logic              pop_req,
    input  logic [CW-1:0]     pop_ch,
    output logic              pop_valid,
    output logic [DW-1:0]     pop_data,
    output logic              push_ovf,
    output logic              pop_unf,
    output logic [NUM_CH-1:0] rx_dma_req,
    output logic [NUM_CH-1:0] tx_dma_req
);
    localparam int CNTW  = BPW + 3;
    localparam int DEPTH = NUM_BLOCKS * DWORDS_PER_BLOCK;
    localparam int AW    = BPW + 2;

    cfg_sel_e        sel;
    logic [BPW-1:0]  wr_blk_a [NUM_CH];
    logic [1:0]      wr_off_a [NUM_CH];
    logic [BPW-1:0]  rd_blk_a [NUM_CH];
    logic [1:0]      rd_off_a [NUM_CH];
    logic [CNTW-1:0] cnt_a    [NUM_CH];
    logic [NUM_CH-1:0] bound_v;
    logic [NUM_CH-1:0] bind_v;
    logic [BPW-1:0]  psh_blk, pop_blk, psh_nxt, pop_nxt;
    logic [1:0]      psh_off, pop_off;
    logic            psh_full, push_ok, pop_ok;

    assign sel = cfg_sel_e'(cfg_sel);

    // Select the pushed and popped channel positions; judge full and empty.
    always_comb begin
        psh_blk  = wr_blk_a[push_ch];
        psh_off  = wr_off_a[push_ch];
        pop_blk  = rd_blk_a[pop_ch];
        pop_off  = rd_off_a[pop_ch];
        psh_full = (cnt_a[push_ch] != '0) && (psh_blk == rd_blk_a[push_ch])
                   && (psh_off == rd_off_a[push_ch]);
        push_ok  = push_valid && bound_v[push_ch] && !psh_full && !bind_v[push_ch];
        pop_ok   = pop_req && (cnt_a[pop_ch] != '0) && !bind_v[pop_ch];
    end

    blkfifo_link_ram #(.NUM_BLOCKS(NUM_BLOCKS)) i_link (
        .clk     (clk),
        .we      (cfg_we && (sel == CFG_NEXT)),
        .waddr   (cfg_idx[BPW-1:0]),
        .wdata   (cfg_data[BPW-1:0]),
        .raddr_a (psh_blk),
        .rdata_a (psh_nxt),
        .raddr_b (pop_blk),
        .rdata_b (pop_nxt)
    );

    blkfifo_data_ram #(.DEPTH(DEPTH), .DW(DW)) i_pool (
        .clk   (clk),
        .we    (push_ok),
        .waddr ({psh_blk, psh_off}),
        .wdata (push_data),
        .re    (pop_ok),
        .raddr ({pop_blk, pop_off}),
        .rdata (pop_data)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign bind_v[c] = cfg_we && (sel == CFG_START) && (cfg_idx == IW'(c));

        blkfifo_chan_ctl #(.BPW(BPW)) i_ctl (
            .clk         (clk),
            .rst_n       (rst_n),
            .bind_en     (bind_v[c]),
            .bind_blk    (cfg_data[BPW-1:0]),
            .push_en     (push_ok && (push_ch == CW'(c))),
            .pop_en      (pop_ok && (pop_ch == CW'(c))),
            .wr_next_blk (psh_nxt),
            .rd_next_blk (pop_nxt),
            .wr_blk      (wr_blk_a[c]),
            .wr_off      (wr_off_a[c]),
            .rd_blk      (rd_blk_a[c]),
            .rd_off      (rd_off_a[c]),
            .count       (cnt_a[c]),
            .bound       (bound_v[c])
        );

        blkfifo_wm_cmp #(.BPW(BPW)) i_wm (
            .clk     (clk),
            .rx_we   (cfg_we && (sel == CFG_RXWM) && (cfg_idx == IW'(c))),
            .tx_we   (cfg_we && (sel == CFG_TXWM) && (cfg_idx == IW'(c))),
            .wm_data (cfg_data),
            .count   (cnt_a[c]),
            .bound   (bound_v[c]),
            .rx_req  (rx_dma_req[c]),
            .tx_req  (tx_dma_req[c])
        );
    end

    // Register the per-operation outcome flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            push_ovf  <= 1'b0;
            pop_unf   <= 1'b0;
            pop_valid <= 1'b0;
        end else begin
            push_ovf  <= push_valid && !push_ok;
            pop_unf   <= pop_req && !pop_ok;
            pop_valid <= pop_ok;
        end
    end
endmodule

// File: rtl/blkfifo_alloc_chk.sv
// Port-level protocol checks for blkfifo_alloc, attached by bind.
module blkfifo_alloc_chk #(
    parameter int NUM_CH = 8,
    parameter int DW     = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              push_valid,
    input logic              pop_req,
    input logic              pop_valid,
    input logic [DW-1:0]     pop_data,
    input logic              push_ovf,
    input logic              pop_unf,
    input logic [NUM_CH-1:0] rx_dma_req,
    input logic [NUM_CH-1:0] tx_dma_req
);
    // R1: quiet outputs right after reset
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!push_ovf && !pop_unf && !pop_valid
                           && rx_dma_req == '0 && tx_dma_req == '0));

    // R2: returned data follows a pop request
    p_valid_follows_pop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pop_valid |-> $past(pop_req));

    // R4: an overflow flag follows a push attempt
    p_ovf_follows_push_r4: assert property (@(posedge clk) disable iff (!rst_n)
        push_ovf |-> $past(push_valid));

    // R5: underflow follows a pop, returns nothing and keeps the data
    p_unf_no_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pop_unf |-> ($past(pop_req) && !pop_valid));

    p_unf_hold_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pop_unf |-> $stable(pop_data));
endmodule

bind blkfifo_alloc blkfifo_alloc_chk #(.NUM_CH(NUM_CH), .DW(DW)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (push_valid),
    .pop_req    (pop_req),
    .pop_valid  (pop_valid),
    .pop_data   (pop_data),
    .push_ovf   (push_ovf),
    .pop_unf    (pop_unf),
    .rx_dma_req (rx_dma_req),
    .tx_dma_req (tx_dma_req)
);

// File: tb/test_blkfifo_alloc.sv
`timescale 1ns/1ps
module test_blkfifo_alloc;
    localparam int NB = 64;
    localparam int NC = 8;
    localparam int DW = 32;
    localparam int BPW = 6;
    localparam int CW = 3;
    localparam int WMW = 7;
    localparam int IW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_sel = '0;
    logic [IW-1:0] cfg_idx = '0;
    logic [WMW-1:0] cfg_data = '0;
    logic push_valid = 1'b0;
    logic [CW-1:0] push_ch = '0;
    logic [DW-1:0] push_data = '0;
    logic pop_req = 1'b0;
    logic [CW-1:0] pop_ch = '0;
    logic pop_valid, push_ovf, pop_unf;
    logic [DW-1:0] pop_data;
    logic [NC-1:0] rx_dma_req, tx_dma_req;

    always #2 clk = ~clk;

    blkfifo_alloc #(.NUM_BLOCKS(NB), .NUM_CH(NC), .DW(DW)) i_blkfifo_alloc (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_idx(cfg_idx), .cfg_data(cfg_data), .push_valid(push_valid),
        .push_ch(push_ch), .push_data(push_data), .pop_req(pop_req),
        .pop_ch(pop_ch), .pop_valid(pop_valid), .pop_data(pop_data),
        .push_ovf(push_ovf), .pop_unf(pop_unf),
        .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req)
    );

    int ring_len [NC] = '{4, 4, 6, 8, 10, 8, 12, 12};
    int ring_base [NC];
    int hwm_m [NC];
    int lwm_m [NC];
    int pushed [NC];
    int popped [NC];
    bit bound_m [NC];
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    function automatic int phys(int j);
        return (j * 37) % NB;
    endfunction

    function automatic logic [DW-1:0] pat(int c, int s);
        return {8'(c + 16), 24'(s * 7 + 3)};
    endfunction

    task automatic check_eq(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Requests recomputed from the model's dword counts.
    task automatic check_reqs();
        for (int c = 0; c < NC; c++) begin
            int cnt = pushed[c] - popped[c];
            bit erx = bound_m[c] && (hwm_m[c] != 0) && ((cnt / 4) >= hwm_m[c]);
            bit etx = bound_m[c] && (((cnt + 3) / 4) <= lwm_m[c]);
            check_eq("R6", $sformatf("rx_dma_req ch%0d", c), 32'(rx_dma_req[c]), 32'(erx));
            check_eq("R7", $sformatf("tx_dma_req ch%0d", c), 32'(tx_dma_req[c]), 32'(etx));
        end
    endtask

    task automatic cfg(int sel, int idx, int data);
        cfg_we = 1'b1;
        cfg_sel = 2'(sel);
        cfg_idx = IW'(idx);
        cfg_data = WMW'(data);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic bind_ch(int c, int blk);
        cfg(1, c, blk);
        popped[c] = pushed[c];
        bound_m[c] = 1'b1;
    endtask

    // One cycle of push and/or pop, then check flags, data and requests.
    task automatic op(bit pv, int pc, bit qv, int qc, string tag);
        int cp = pushed[pc] - popped[pc];
        int cq = pushed[qc] - popped[qc];
        bit pok = pv && bound_m[pc] && (cp < 4 * ring_len[pc]);
        bit qok = qv && (cq > 0);
        logic [DW-1:0] exp_d = pat(qc, popped[qc]);
        push_valid = pv;
        push_ch = CW'(pc);
        push_data = pat(pc, pushed[pc]);
        pop_req = qv;
        pop_ch = CW'(qc);
        @(negedge clk);
        push_valid = 1'b0;
        pop_req = 1'b0;
        if (pv) check_eq(tag, $sformatf("push_ovf ch%0d", pc), 32'(push_ovf), 32'(!pok));
        if (qv) begin
            check_eq(tag, $sformatf("pop_unf ch%0d", qc), 32'(pop_unf), 32'(!qok));
            check_eq(tag, $sformatf("pop_valid ch%0d", qc), 32'(pop_valid), 32'(qok));
            if (qok) check_eq(tag, $sformatf("pop_data ch%0d", qc), pop_data, exp_d);
        end
        if (pok) pushed[pc]++;
        if (qok) popped[qc]++;
        check_reqs();
    endtask

    task automatic check_quiet(string tag);
        check_eq(tag, "rx_dma_req", 32'(rx_dma_req), 32'd0);
        check_eq(tag, "tx_dma_req", 32'(tx_dma_req), 32'd0);
        check_eq(tag, "push_ovf", 32'(push_ovf), 32'd0);
        check_eq(tag, "pop_unf", 32'(pop_unf), 32'd0);
        check_eq(tag, "pop_valid", 32'(pop_valid), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int acc = 0;
        for (int c = 0; c < NC; c++) begin
            ring_base[c] = acc;
            acc += ring_len[c];
            hwm_m[c] = (c % ring_len[c]) + 1;
            lwm_m[c] = c % 4;
            pushed[c] = 0;
            popped[c] = 0;
            bound_m[c] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // Clear every pointer and threshold entry by writing zero.
        for (int b = 0; b < NB; b++) cfg(0, b, 0);
        for (int c = 0; c < NC; c++) begin
            cfg(2, c, 0);
            cfg(3, c, 0);
            cfg(1, c, 0);
        end
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check_quiet("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_quiet("R1");
        // Unbound channel: push dropped, pop empty.
        op(1'b1, 0, 1'b0, 0, "R4");
        op(1'b0, 0, 1'b1, 0, "R5");

        // Build scrambled rings, thresholds, bind.
        for (int c = 0; c < NC; c++) begin
            for (int k = 0; k < ring_len[c]; k++)
                cfg(0, phys(ring_base[c] + k), phys(ring_base[c] + (k + 1) % ring_len[c]));
            cfg(2, c, hwm_m[c]);
            cfg(3, c, lwm_m[c]);
            bind_ch(c, phys(ring_base[c]));
        end
        check_reqs();

        // Per-channel sweep: offset start, fill to overflow, drain to underflow.
        for (int c = 0; c < NC; c++) begin
            repeat (5) op(1'b1, c, 1'b0, 0, "R2");
            repeat (5) op(1'b0, 0, 1'b1, c, "R2");
            for (int i = 0; i < 4 * ring_len[c]; i++) op(1'b1, c, 1'b0, 0, "R3");
            op(1'b1, c, 1'b0, 0, "R4");
            for (int i = 0; i < 4 * ring_len[c]; i++) op(1'b0, 0, 1'b1, c, "R3");
            op(1'b0, 0, 1'b1, c, "R5");
        end

        // Every ring full at once, then drained.
        for (int r = 0; r < 49; r++)
            for (int c = 0; c < NC; c++) op(1'b1, c, 1'b0, 0, "R8");
        for (int r = 0; r < 49; r++)
            for (int c = 0; c < NC; c++) op(1'b0, 0, 1'b1, c, "R8");

        // Push on one channel while popping another.
        for (int i = 0; i < 200; i++) op(1'b1, i % NC, 1'b1, (i * 3 + 1) % NC, "R8");

        // Same-channel push and pop in one cycle, including at full.
        repeat (3) op(1'b1, 2, 1'b0, 0, "R10");
        repeat (30) op(1'b1, 2, 1'b1, 2, "R10");
        repeat (30) op(1'b1, 2, 1'b0, 0, "R10");
        repeat (4) op(1'b1, 2, 1'b1, 2, "R10");
        repeat (30) op(1'b0, 0, 1'b1, 2, "R10");

        // Rebind a partly filled channel mid-ring.
        repeat (7) op(1'b1, 5, 1'b0, 0, "R9");
        bind_ch(5, phys(ring_base[5] + 2));
        check_reqs();
        op(1'b0, 0, 1'b1, 5, "R9");
        for (int i = 0; i < 4 * ring_len[5]; i++) op(1'b1, 5, 1'b0, 0, "R9");
        op(1'b1, 5, 1'b0, 0, "R9");
        for (int i = 0; i < 4 * ring_len[5]; i++) op(1'b0, 0, 1'b1, 5, "R9");

        // Reset keeps rings and thresholds; rebind and reuse them.
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int c = 0; c < NC; c++) begin
            bound_m[c] = 1'b0;
            popped[c] = pushed[c];
        end
        @(negedge clk);
        check_quiet("R1");
        for (int c = 0; c < NC; c++) bind_ch(c, phys(ring_base[c]));
        check_reqs();
        for (int c = 6; c < NC; c++) begin
            for (int i = 0; i < 4 * ring_len[c]; i++) op(1'b1, c, 1'b0, 0, "R11");
            op(1'b1, c, 1'b0, 0, "R11");
            for (int i = 0; i < 4 * ring_len[c]; i++) op(1'b0, 0, 1'b1, c, "R11");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule